// File: doc/BRIEF.md
# Burst Memory Slave for a Processor Memory Port

The block is a synthesizable AXI4 slave that stands in for main memory behind a processor's memory port. It holds an on-chip word array with byte write enables. It accepts incrementing read and write bursts, and every response it returns is OKAY.

A read request is taken on the read-address channel. The block then walks the burst one beat per cycle. Each beat goes into a response FIFO together with the request ID and an end-of-burst flag. The read-address channel stays closed while a burst is being walked, and the walk pauses whenever the FIFO is full, so a slow master loses no data.

Writes are handled one burst at a time. The write-address channel opens only when no write is in flight and the write-response FIFO has room. The write-data channel opens only while a write is in flight. Each data beat is merged into memory under its byte strobes. After the final beat, the latched ID is queued as a write response.

A beat of size code `s` spans `1 << s` bytes. Beat `i` of a burst uses address `base + i*(1 << s)`. Data sits on the byte lanes given by the low address bits, so several narrow beats can fill different lanes of one word. Any access whose word index falls at or beyond the memory depth sets a sticky error output and is suppressed.

Top module: `axi_mem_slave`

## Requirements
- R1: While `rst_ni` is low, and until the first rising clock edge after its release, every ready and valid output is 0 and every response field (`r_data_o`, `r_id_o`, `r_resp_o`, `r_last_o`, `b_id_o`, `b_resp_o`) is 0.
- R2: An accepted read with length field `len` returns exactly `len+1` R beats in order, all carrying the request ID. Beat `i` carries the memory word that holds byte address `base + i*(1 << size)`.
- R3: `r_last_o` is 1 on the final beat of each read burst and 0 on every other beat.
- R4: `ar_ready_o` is 0 from the cycle after a read-address handshake until the whole burst has entered the R FIFO. While `r_ready_i` is low, no beat is dropped or reordered.
- R5: `aw_ready_o` and `w_ready_o` are never 1 together. After a write-address handshake, `aw_ready_o` is 0 and `w_ready_o` is 1 until the final data beat is taken, and afterwards `w_ready_o` is 0.
- R6: On a write beat, byte lane `k` of the addressed word (bits `8k+7:8k`) is updated only when `w_strb_i[k]` is 1. The beat address advances by `1 << size` bytes per beat, so narrow beats select lanes by their low address bits.
- R7: After the final data beat of a write burst, exactly one B response carrying the burst's write ID is returned. `w_last_i` must be 1 on that beat.
- R8: `r_resp_o` and `b_resp_o` are always 2'b00 (OKAY) on every response beat.
- R9: `r_valid_o` and `b_valid_o` are 1 exactly when their FIFO holds an entry. An entry is removed only on a valid-and-ready handshake, and the presented fields stay stable while ready is low.
- R10: A beat whose word index is at or beyond the memory depth sets `err_o`, which stays 1 until reset. Such a write changes no stored word, and such a read beat returns all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ar_valid_i | input | 1 | Read request valid |
| ar_ready_o | output | 1 | Read request accepted |
| ar_addr_i | input | ADDR_W | Read burst start byte address |
| ar_id_i | input | ID_W | Read transaction ID |
| ar_size_i | input | 3 | Read beat size code (bytes = 1 << code) |
| ar_len_i | input | 8 | Read beats minus one |
| aw_valid_i | input | 1 | Write request valid |
| aw_ready_o | output | 1 | Write request accepted |
| aw_addr_i | input | ADDR_W | Write burst start byte address |
| aw_id_i | input | ID_W | Write transaction ID |
| aw_size_i | input | 3 | Write beat size code |
| aw_len_i | input | 8 | Write beats minus one |
| w_valid_i | input | 1 | Write data valid |
| w_ready_o | output | 1 | Write data accepted |
| w_data_i | input | DATA_W | Write data |
| w_strb_i | input | DATA_W/8 | Byte lane enables |
| w_last_i | input | 1 | Final write beat marker |
| r_valid_o | output | 1 | Read beat valid |
| r_ready_i | input | 1 | Master takes read beat |
| r_data_o | output | DATA_W | Read data |
| r_id_o | output | ID_W | Read beat ID |
| r_resp_o | output | 2 | Read response code |
| r_last_o | output | 1 | Final beat of read burst |
| b_valid_o | output | 1 | Write response valid |
| b_ready_i | input | 1 | Master takes write response |
| b_id_o | output | ID_W | Write response ID |
| b_resp_o | output | 2 | Write response code |
| err_o | output | 1 | Sticky out-of-range access flag |

## Verification
The bench targets bursts longer than the R FIFO, issued while `r_ready_i` stalls in a fixed pattern. A walker that kept pushing into a full FIFO would lose beats or send the wrong count, and a walker that reopened the address channel too early would interleave two bursts. Byte-wide beats that fill one word lane by lane, and a partial-strobe beat, are both tested: a design that ignored the strobes or stepped by a whole word would corrupt neighbouring bytes or skip lanes. An out-of-range write is aimed at an address whose low index bits alias word 0, so truncated decoding would show up as a changed word 0. Finally, a stalled read checks that the head beat stays put, and write responses are matched against their IDs so that a lost or duplicated B response is caught.

// File: rtl/axi_mem_pkg.sv
package axi_mem_pkg;
  localparam int unsigned LEN_W  = 8;
  localparam int unsigned SIZE_W = 3;
  localparam int unsigned CNT_W  = LEN_W + 1;
  localparam logic [1:0]  RESP_OKAY = 2'b00;
endpackage

// File: rtl/axi_mem_fifo.sv
module axi_mem_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign data_o  = store_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= bump(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) store_q[wr_ptr_q] <= data_i;
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  // R9
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/axi_mem_array.sv
module axi_mem_array #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                rd_oor_o,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [DATA_W/8-1:0] wr_strb_i,
  output logic                wr_oor_o
);
  localparam int unsigned STRB_W  = DATA_W / 8;
  localparam int unsigned OFF_W   = (STRB_W > 1) ? $clog2(STRB_W) : 0;
  localparam int unsigned IDX_W   = $clog2(DEPTH);
  localparam int unsigned WADDR_W = ADDR_W - OFF_W;

  logic [DATA_W-1:0]  mem_q [DEPTH];
  logic [WADDR_W-1:0] rd_word, wr_word;
  logic [DATA_W-1:0]  old_word, merged;

  assign rd_word  = rd_addr_i[ADDR_W-1:OFF_W];
  assign wr_word  = wr_addr_i[ADDR_W-1:OFF_W];
  assign rd_oor_o = (rd_word >= WADDR_W'(DEPTH));
  assign wr_oor_o = (wr_word >= WADDR_W'(DEPTH));

  assign rd_data_o = rd_oor_o ? '0 : mem_q[rd_word[IDX_W-1:0]];
  assign old_word  = mem_q[wr_word[IDX_W-1:0]];

  for (genvar b = 0; b < STRB_W; b++) begin : g_lane
    assign merged[8*b +: 8] = wr_strb_i[b] ? wr_data_i[8*b +: 8] : old_word[8*b +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i && !wr_oor_o) begin
      mem_q[wr_word[IDX_W-1:0]] <= merged;
    end
  end
endmodule

// File: rtl/axi_mem_rd_walker.sv
module axi_mem_rd_walker
  import axi_mem_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              live_i,
  input  logic              ar_valid_i,
  output logic              ar_ready_o,
  input  logic [ADDR_W-1:0] ar_addr_i,
  input  logic [ID_W-1:0]   ar_id_i,
  input  logic [SIZE_W-1:0] ar_size_i,
  input  logic [LEN_W-1:0]  ar_len_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              fifo_full_i,
  output logic              push_o,
  output logic [ID_W+DATA_W:0] push_data_o
);
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ID_W-1:0]   id_q;
  logic [SIZE_W-1:0] size_q;
  logic [CNT_W-1:0]  left_q;
  logic              ar_fire, final_beat;

  assign ar_ready_o  = live_i && !busy_q;
  assign ar_fire     = ar_valid_i && ar_ready_o;
  assign push_o      = busy_q && !fifo_full_i;
  assign final_beat  = (left_q == CNT_W'(1));
  assign mem_addr_o  = addr_q;
  assign push_data_o = {id_q, mem_data_i, final_beat};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      id_q   <= '0;
      size_q <= '0;
      left_q <= '0;
    end else if (ar_fire) begin
      busy_q <= 1'b1;
      addr_q <= ar_addr_i;
      id_q   <= ar_id_i;
      size_q <= ar_size_i;
      left_q <= CNT_W'(ar_len_i) + CNT_W'(1);
    end else if (push_o) begin
      addr_q <= addr_q + (ADDR_W'(1) << size_q);
      left_q <= left_q - CNT_W'(1);
      if (final_beat) busy_q <= 1'b0;
    end
  end

  // R4
  ar_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_fire |=> !ar_ready_o);
endmodule

// File: rtl/axi_mem_wr_walker.sv
module axi_mem_wr_walker
  import axi_mem_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned ADDR_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                live_i,
  input  logic                aw_valid_i,
  output logic                aw_ready_o,
  input  logic [ADDR_W-1:0]   aw_addr_i,
  input  logic [ID_W-1:0]     aw_id_i,
  input  logic [SIZE_W-1:0]   aw_size_i,
  input  logic [LEN_W-1:0]    aw_len_i,
  input  logic                w_valid_i,
  output logic                w_ready_o,
  input  logic [DATA_W-1:0]   w_data_i,
  input  logic [DATA_W/8-1:0] w_strb_i,
  input  logic                w_last_i,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_data_o,
  output logic [DATA_W/8-1:0] mem_strb_o,
  input  logic                b_full_i,
  output logic                b_push_o,
  output logic [ID_W-1:0]     b_id_o
);
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ID_W-1:0]   id_q;
  logic [SIZE_W-1:0] size_q;
  logic [CNT_W-1:0]  left_q;
  logic              aw_fire, w_fire, final_beat;

  assign aw_ready_o = live_i && !busy_q && !b_full_i;
  assign w_ready_o  = live_i && busy_q;
  assign aw_fire    = aw_valid_i && aw_ready_o;
  assign w_fire     = w_valid_i && w_ready_o;
  assign final_beat = (left_q == CNT_W'(1));

  assign mem_we_o   = w_fire;
  assign mem_addr_o = addr_q;
  assign mem_data_o = w_data_i;
  assign mem_strb_o = w_strb_i;
  assign b_push_o   = w_fire && final_beat;
  assign b_id_o     = id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      id_q   <= '0;
      size_q <= '0;
      left_q <= '0;
    end else if (aw_fire) begin
      busy_q <= 1'b1;
      addr_q <= aw_addr_i;
      id_q   <= aw_id_i;
      size_q <= aw_size_i;
      left_q <= CNT_W'(aw_len_i) + CNT_W'(1);
    end else if (w_fire) begin
      addr_q <= addr_q + (ADDR_W'(1) << size_q);
      left_q <= left_q - CNT_W'(1);
      if (final_beat) busy_q <= 1'b0;
    end
  end

  // R5
  aw_w_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(aw_ready_o && w_ready_o));
  // R7
  w_last_final_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_fire && final_beat) |-> w_last_i);
endmodule

// File: rtl/axi_mem_slave.sv
module axi_mem_slave
  import axi_mem_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ID_W        = 4,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DEPTH       = 64,
  parameter int unsigned RFIFO_DEPTH = 8,
  parameter int unsigned BFIFO_DEPTH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ar_valid_i,
  output logic                ar_ready_o,
  input  logic [ADDR_W-1:0]   ar_addr_i,
  input  logic [ID_W-1:0]     ar_id_i,
  input  logic [2:0]          ar_size_i,
  input  logic [7:0]          ar_len_i,
  input  logic                aw_valid_i,
  output logic                aw_ready_o,
  input  logic [ADDR_W-1:0]   aw_addr_i,
  input  logic [ID_W-1:0]     aw_id_i,
  input  logic [2:0]          aw_size_i,
  input  logic [7:0]          aw_len_i,
  input  logic                w_valid_i,
  output logic                w_ready_o,
  input  logic [DATA_W-1:0]   w_data_i,
  input  logic [DATA_W/8-1:0] w_strb_i,
  input  logic                w_last_i,
  output logic                r_valid_o,
  input  logic                r_ready_i,
  output logic [DATA_W-1:0]   r_data_o,
  output logic [ID_W-1:0]     r_id_o,
  output logic [1:0]          r_resp_o,
  output logic                r_last_o,
  output logic                b_valid_o,
  input  logic                b_ready_i,
  output logic [ID_W-1:0]     b_id_o,
  output logic [1:0]          b_resp_o,
  output logic                err_o
);
  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned RENT_W = ID_W + DATA_W + 1;

  logic live_q, err_q;

  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic [STRB_W-1:0] wr_strb;
  logic              rd_oor, wr_oor, wr_en;

  logic              r_push, r_full, r_empty, r_pop;
  logic [RENT_W-1:0] r_in, r_head;
  logic              b_push, b_full, b_empty, b_pop;
  logic [ID_W-1:0]   b_in, b_head;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  axi_mem_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
    .clk_i, .rst_ni,
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_oor_o(rd_oor),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .wr_strb_i(wr_strb), .wr_oor_o(wr_oor)
  );

  axi_mem_rd_walker #(.DATA_W(DATA_W), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_i, .rst_ni, .live_i(live_q),
    .ar_valid_i, .ar_ready_o, .ar_addr_i, .ar_id_i, .ar_size_i, .ar_len_i,
    .mem_addr_o(rd_addr), .mem_data_i(rd_data),
    .fifo_full_i(r_full), .push_o(r_push), .push_data_o(r_in)
  );

  axi_mem_wr_walker #(.DATA_W(DATA_W), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_wr (
    .clk_i, .rst_ni, .live_i(live_q),
    .aw_valid_i, .aw_ready_o, .aw_addr_i, .aw_id_i, .aw_size_i, .aw_len_i,
    .w_valid_i, .w_ready_o, .w_data_i, .w_strb_i, .w_last_i,
    .mem_we_o(wr_en), .mem_addr_o(wr_addr), .mem_data_o(wr_data), .mem_strb_o(wr_strb),
    .b_full_i(b_full), .b_push_o(b_push), .b_id_o(b_in)
  );

  axi_mem_fifo #(.WIDTH(RENT_W), .DEPTH(RFIFO_DEPTH)) u_rfifo (
    .clk_i, .rst_ni, .push_i(r_push), .data_i(r_in), .pop_i(r_pop),
    .data_o(r_head), .full_o(r_full), .empty_o(r_empty)
  );

  axi_mem_fifo #(.WIDTH(ID_W), .DEPTH(BFIFO_DEPTH)) u_bfifo (
    .clk_i, .rst_ni, .push_i(b_push), .data_i(b_in), .pop_i(b_pop),
    .data_o(b_head), .full_o(b_full), .empty_o(b_empty)
  );

  assign r_valid_o = !r_empty;
  assign r_pop     = r_valid_o && r_ready_i;
  assign r_id_o    = r_valid_o ? r_head[RENT_W-1 -: ID_W] : '0;
  assign r_data_o  = r_valid_o ? r_head[DATA_W:1] : '0;
  assign r_last_o  = r_valid_o && r_head[0];
  assign r_resp_o  = RESP_OKAY;

  assign b_valid_o = !b_empty;
  assign b_pop     = b_valid_o && b_ready_i;
  assign b_id_o    = b_valid_o ? b_head : '0;
  assign b_resp_o  = RESP_OKAY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if ((r_push && rd_oor) || (wr_en && wr_oor)) err_q <= 1'b1;
  end
  assign err_o = err_q;

  // R1
  quiet_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live_q |-> !(ar_ready_o || aw_ready_o || w_ready_o || r_valid_o || b_valid_o));
  // R9
  r_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_valid_o && !r_ready_i) |=> (r_valid_o && $stable(r_data_o) && $stable(r_id_o) && $stable(r_last_o)));
  // R9
  b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_valid_o && !b_ready_i) |=> (b_valid_o && $stable(b_id_o)));
  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: tb/axi_mem_slave_tb.sv
module axi_mem_slave_tb;
  localparam int DATA_W = 32, ID_W = 4, ADDR_W = 16, DEPTH = 64;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic              ar_valid_i = 0, aw_valid_i = 0, w_valid_i = 0, w_last_i = 0;
  logic [ADDR_W-1:0] ar_addr_i = '0, aw_addr_i = '0;
  logic [ID_W-1:0]   ar_id_i = '0, aw_id_i = '0;
  logic [2:0]        ar_size_i = '0, aw_size_i = '0;
  logic [7:0]        ar_len_i = '0, aw_len_i = '0;
  logic [DATA_W-1:0] w_data_i = '0;
  logic [3:0]        w_strb_i = '0;
  logic              r_ready_i = 0, b_ready_i = 0;
  logic              ar_ready_o, aw_ready_o, w_ready_o, r_valid_o, r_last_o, b_valid_o, err_o;
  logic [DATA_W-1:0] r_data_o;
  logic [ID_W-1:0]   r_id_o, b_id_o;
  logic [1:0]        r_resp_o, b_resp_o;

  axi_mem_slave u_dut (.*);

  int checks = 0, errors = 0, cyc = 0, rr_mode = 0, br_mode = 0;
  bit run = 0, finished = 0;
  logic [DATA_W-1:0] ref_mem [DEPTH];
  logic [ID_W+DATA_W:0] exp_r[$];
  logic [ID_W-1:0] exp_b[$];
  logic [DATA_W-1:0] wdat [16];
  logic [3:0] wstb [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: ready set for the coming edge, then handshake compared
  always @(negedge clk_i) begin
    cyc++;
    if (run) begin
      r_ready_i = (rr_mode == 0) ? 1'b1 : (rr_mode == 1) ? (cyc % 3 != 0) : 1'b0;
      b_ready_i = (br_mode == 0) ? 1'b1 : (cyc % 2 == 0);
      if (r_valid_o && r_ready_i) begin
        if (exp_r.size() == 0) chk(0, "R2", "unexpected R beat", {32'b0, r_data_o}, 0);
        else begin
          logic [ID_W+DATA_W:0] e;
          e = exp_r.pop_front();
          chk(r_data_o == e[DATA_W:1], "R2", "r_data", r_data_o, e[DATA_W:1]);
          chk(r_id_o == e[ID_W+DATA_W -: ID_W], "R2", "r_id", r_id_o, e[ID_W+DATA_W -: ID_W]);
          chk(r_last_o == e[0], "R3", "r_last", r_last_o, e[0]);
          chk(r_resp_o == 2'b00, "R8", "r_resp", r_resp_o, 0);
        end
      end
      if (b_valid_o && b_ready_i) begin
        if (exp_b.size() == 0) chk(0, "R7", "unexpected B", b_id_o, 0);
        else begin
          logic [ID_W-1:0] eb;
          eb = exp_b.pop_front();
          chk(b_id_o == eb, "R7", "b_id", b_id_o, eb);
          chk(b_resp_o == 2'b00, "R8", "b_resp", b_resp_o, 0);
        end
      end
    end
  end

  task automatic do_read(input int addr, input int id, input int size, input int len);
    for (int i = 0; i <= len; i++) begin
      int a, w;
      logic [DATA_W-1:0] d;
      a = addr + (i << size);
      w = a >> 2;
      d = (w < DEPTH) ? ref_mem[w] : '0;
      exp_r.push_back({ID_W'(id), d, (i == len)});
    end
    @(negedge clk_i);
    ar_valid_i = 1; ar_addr_i = ADDR_W'(addr); ar_id_i = ID_W'(id);
    ar_size_i = 3'(size); ar_len_i = 8'(len);
    while (!ar_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    ar_valid_i = 0;
    chk(ar_ready_o == 0, "R4", "ar_ready after accept", ar_ready_o, 0);
  endtask

  task automatic do_write(input int addr, input int id, input int size, input int len);
    @(negedge clk_i);
    aw_valid_i = 1; aw_addr_i = ADDR_W'(addr); aw_id_i = ID_W'(id);
    aw_size_i = 3'(size); aw_len_i = 8'(len);
    while (!aw_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    aw_valid_i = 0;
    chk(aw_ready_o == 0 && w_ready_o == 1, "R5", "aw/w ready in flight",
        {aw_ready_o, w_ready_o}, 2'b01);
    for (int i = 0; i <= len; i++) begin
      int a, w;
      a = addr + (i << size);
      w = a >> 2;
      w_valid_i = 1; w_data_i = wdat[i]; w_strb_i = wstb[i]; w_last_i = (i == len);
      while (!w_ready_o) @(negedge clk_i);
      if (w < DEPTH)
        for (int k = 0; k < 4; k++)
          if (wstb[i][k]) ref_mem[w][8*k +: 8] = wdat[i][8*k +: 8];
      if (i == len) exp_b.push_back(ID_W'(id));
      @(negedge clk_i);
    end
    w_valid_i = 0; w_last_i = 0;
    chk(w_ready_o == 0, "R5", "w_ready after final beat", w_ready_o, 0);
  endtask

  task automatic drain();
    int t;
    t = 0;
    while ((exp_r.size() != 0 || exp_b.size() != 0) && t < 2000) begin
      @(negedge clk_i); t++;
    end
    repeat (3) @(negedge clk_i);
    chk(exp_r.size() == 0, "R2", "R beats outstanding", exp_r.size(), 0);
    chk(exp_b.size() == 0, "R7", "B responses outstanding", exp_b.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk_i);
    // R1: quiet in reset
    chk({ar_ready_o, aw_ready_o, w_ready_o, r_valid_o, b_valid_o} == 0, "R1",
        "ready/valid in reset", {ar_ready_o, aw_ready_o, w_ready_o, r_valid_o, b_valid_o}, 0);
    chk({r_data_o, r_id_o, r_resp_o, r_last_o, b_id_o, b_resp_o} == 0, "R1",
        "response fields in reset", r_data_o, 0);
    rst_ni = 1'b1;
    #1;
    chk({ar_ready_o, aw_ready_o, w_ready_o, r_valid_o, b_valid_o} == 0, "R1",
        "ready/valid before first edge", {ar_ready_o, aw_ready_o}, 0);
    @(negedge clk_i);
    chk(ar_ready_o == 1 && aw_ready_o == 1, "R1", "ready after start",
        {ar_ready_o, aw_ready_o}, 2'b11);
    chk(err_o == 0, "R10", "err_o clear", err_o, 0);
    run = 1;

    // full-word write burst then read back (R2, R3, R5, R7)
    for (int i = 0; i < 16; i++) begin
      wdat[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0101; wstb[i] = 4'hF;
    end
    do_write(0, 3, 2, 3);
    drain();
    do_read(0, 5, 2, 3);
    drain();

    // R6: byte beats filling one word lane by lane
    for (int i = 0; i < 4; i++) begin
      wdat[i] = {4{8'(8'hA0 + i)}}; wstb[i] = 4'(1 << i);
    end
    do_write(32'h20, 9, 0, 3);
    drain();
    do_read(32'h20, 2, 2, 0);
    drain();
    chk(ref_mem[8] == 32'hA3A2A1A0, "R6", "bench lane model", ref_mem[8], 32'hA3A2A1A0);

    // R6: partial strobe
    wdat[0] = 32'hFFFF_FFFF; wstb[0] = 4'b0101;
    do_write(4, 6, 2, 0);
    drain();
    do_read(4, 1, 2, 0);
    drain();

    // R4: long burst past FIFO depth under stalls, two bursts queued
    for (int i = 0; i < 16; i++) begin
      wdat[i] = 32'hC0DE_0000 + 32'(i); wstb[i] = 4'hF;
    end
    do_write(32'h40, 12, 2, 15);
    drain();
    rr_mode = 1; br_mode = 1;
    do_read(32'h40, 7, 2, 15);
    do_read(32'h44, 8, 2, 4);
    drain();

    // R9: stalled head beat stays put
    rr_mode = 2;
    do_read(32'h48, 4, 2, 1);
    repeat (5) @(negedge clk_i);
    chk(r_valid_o == 1, "R9", "r_valid held while stalled", r_valid_o, 1);
    chk(r_data_o == exp_r[0][DATA_W:1], "R9", "head beat data held", r_data_o, exp_r[0][DATA_W:1]);
    rr_mode = 0;
    drain();

    // R10: out-of-range write aliasing word 0 is dropped, read gives zero
    wdat[0] = 32'hDEAD_BEEF; wstb[0] = 4'hF;
    do_write(32'h100, 10, 2, 0);
    drain();
    chk(err_o == 1, "R10", "err_o set", err_o, 1);
    do_read(32'h100, 11, 2, 0);
    do_read(0, 13, 2, 0);
    drain();
    chk(err_o == 1, "R10", "err_o sticky", err_o, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule